// File: doc/BRIEF.md
# Interrupt Steering Router

This block sits in front of a cascaded pair of interrupt controllers. It places three extra interrupt sources onto the sixteen ISA request lines. Two of the sources are active-low PCI interrupt inputs. The third is an active-low input shared by on-board devices.

Each source has its own routing byte. The byte either disables the source or names one target line. A named source is inverted to active high and ORed onto that line, together with the line's own external request. Only eleven lines can be targets, and a byte that names any other line leaves its source unrouted. A separate control byte holds a mouse-enable bit. This bit decides whether line 12 carries its external pin or an internal mouse interrupt.

The register port is written one byte per clock through a plain select. The interrupt path from inputs to outputs is purely combinational, with no handshake and no latching. A level on any source therefore appears on the outputs at once. The controller lines that receive PCI sources are expected to be programmed for level sensing.

Top module: `irq_steer_router`

## Requirements
- R1: After reset, all three routing bytes read as 0x80 (disabled) and the mouse-enable bit is 0, so `irq_req` equals `isa_irq` whatever the steerable inputs do.
- R2: A routing byte with bit 7 set adds nothing to any output line.
- R3: A routing byte with bit 7 clear and bits 3:0 naming line 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 or 15 drives the inverted source onto that line, ORed with the line's external request. Bits 6:4 are ignored.
- R4: A routing byte whose bits 3:0 name line 0, 1, 2, 8 or 13 is treated as disabled. Those five lines always equal their `isa_irq` bit.
- R5: Several sources routed to one line are ORed together. Every `isa_irq` bit other than bit 12 is always present on its output.
- R6: Control register bit 6 is the mouse-enable bit. When it is 1, the base value of line 12 is `mouse_irq`. When it is 0, the base value is `isa_irq[12]`. Steering onto line 12 is ORed in for either setting. The other control bits have no effect.
- R7: A write happens at a rising clock edge while `cfg_wr` is 1. The select values are: 0 for the PCI A byte, 1 for the PCI B byte, 2 for the on-board byte, and 3 for the control byte. The new value acts from that edge on. Nothing changes while `cfg_wr` is 0.
- R8: Outputs follow the source and `isa_irq` levels in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 PCI A, 1 PCI B, 2 on-board, 3 control) |
| cfg_wdata | input | 8 | Write data |
| pci_irq_n | input | 2 | PCI interrupts, active low (bit 0 = A, bit 1 = B) |
| mb_irq_n | input | 1 | On-board device interrupt, active low |
| mouse_irq | input | 1 | Internal mouse interrupt, active high |
| isa_irq | input | 16 | External ISA requests, active high |
| irq_req | output | 16 | Merged requests to the controller pair |

## Verification
Some properties are checked by the assertions on every cycle. The five lines that cannot be targets always mirror their external bits. No external request other than line 12 is ever lost. Line 12 follows its selected base source. A write lands in the chosen byte, and reset leaves every byte disabled. Other behaviour can only be shown by the bench's scenarios. These include the exact mapping from each routing value to a line, the OR of shared targets, the inversion of the active-low sources, and the absence of any effect from a strobe-low write.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NLINE = 16;
  localparam int NSRC  = 3;
  localparam int LW    = $clog2(NLINE);
  localparam int SELW  = $clog2(NSRC + 1);
  localparam int MOUSE_LINE = 12;
  localparam int MOUSE_BIT  = 6;
  // lines 3-7, 9-12, 14, 15
  localparam logic [NLINE-1:0] TARGET_OK = 16'hDEF8;
  localparam logic [7:0] ROUTE_RST = 8'h80;

  typedef struct packed {
    logic          off;
    logic [6-LW:0] spare;
    logic [LW-1:0] line;
  } route_t;
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [SELW-1:0]       sel,
  input  logic [7:0]            wdata,
  output route_t [NSRC-1:0]     route,
  output logic                  mouse_en
);
  route_t [NSRC-1:0] route_q;
  logic              mouse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= {NSRC{ROUTE_RST}};
      mouse_q <= 1'b0;
    end else if (wr) begin
      if (sel == SELW'(NSRC)) mouse_q <= wdata[MOUSE_BIT];
      else route_q[sel] <= wdata;
    end
  end

  assign route    = route_q;
  assign mouse_en = mouse_q;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_chk
      p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SELW'(gi)) |=> (route[gi] == $past(wdata)));
      p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (route[gi] == ROUTE_RST));
    end
  endgenerate

  p_mouse_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SELW'(NSRC)) |=> (mouse_en == $past(wdata[MOUSE_BIT])));
endmodule

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
(
  input  route_t             route,
  input  logic               req,
  output logic [NLINE-1:0]   hit
);
  logic [NLINE-1:0] onehot;

  always_comb begin
    onehot = '0;
    onehot[route.line] = 1'b1;
    hit = (route.off || !req) ? '0 : (onehot & TARGET_OK);
  end

  always_comb begin
    a_no_bad_target_r4: assert ((hit & ~TARGET_OK) == '0);
  end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_sel,
  input  logic [7:0]   cfg_wdata,
  input  logic [1:0]   pci_irq_n,
  input  logic         mb_irq_n,
  input  logic         mouse_irq,
  input  logic [15:0]  isa_irq,
  output logic [15:0]  irq_req
);
  route_t [NSRC-1:0]  route;
  logic               mouse_en;
  logic [NSRC-1:0]    src_req;
  logic [NLINE-1:0]   hit [NSRC];
  logic [NLINE-1:0]   steered;
  logic [NLINE-1:0]   base;

  irq_steer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .route(route), .mouse_en(mouse_en)
  );

  assign src_req = ~{mb_irq_n, pci_irq_n};

  genvar gs;
  generate
    for (gs = 0; gs < NSRC; gs++) begin : g_src
      irq_steer_decode u_dec (
        .route(route[gs]), .req(src_req[gs]), .hit(hit[gs])
      );
    end
  endgenerate

  always_comb begin
    steered = '0;
    for (int s = 0; s < NSRC; s++) steered = steered | hit[s];
  end

  always_comb begin
    base = isa_irq;
    if (mouse_en) base[MOUSE_LINE] = mouse_irq;
  end

  assign irq_req = base | steered;

  localparam logic [NLINE-1:0] KEEP = ~(NLINE'(1) << MOUSE_LINE);

  p_fixed_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~TARGET_OK) == (isa_irq & ~TARGET_OK)));
  p_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((isa_irq & KEEP & ~irq_req) == '0));
  p_mouse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mouse_en && mouse_irq) |-> irq_req[MOUSE_LINE]);
  p_pin_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mouse_en && isa_irq[MOUSE_LINE]) |-> irq_req[MOUSE_LINE]);
  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (route[0].off && route[1].off && route[2].off && !mouse_en)
      |-> (irq_req == isa_irq));
endmodule

// File: tb/sim_irq_steer_router.sv
module sim_irq_steer_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  pci_irq_n = 2'b11;
  logic        mb_irq_n = 1'b1;
  logic        mouse_irq = 1'b0;
  logic [15:0] isa_irq = '0;
  logic [15:0] irq_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_steer_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pci_irq_n(pci_irq_n), .mb_irq_n(mb_irq_n),
    .mouse_irq(mouse_irq), .isa_irq(isa_irq), .irq_req(irq_req)
  );

  // {ra, rb, rm, ctrl, pci_n[1:0], mb_n, mouse, isa[15:0], expect[15:0]}
  localparam logic [67:0] VEC [12] = '{
    {8'h80,8'h80,8'h80,8'h00,2'b00,1'b0,1'b1,16'h0000,16'h0000}, // R2
    {8'h0B,8'h80,8'h80,8'h00,2'b10,1'b1,1'b0,16'h0000,16'h0800}, // R3
    {8'h0B,8'h80,8'h80,8'h00,2'b11,1'b1,1'b0,16'h0000,16'h0000}, // R3
    {8'h05,8'h0A,8'h0F,8'h00,2'b00,1'b0,1'b0,16'h0001,16'h8421}, // R3
    {8'h09,8'h09,8'h09,8'h00,2'b01,1'b1,1'b0,16'h0000,16'h0200}, // R5
    {8'h0D,8'h08,8'h02,8'h00,2'b00,1'b0,1'b0,16'h0000,16'h0000}, // R4
    {8'h73,8'h8E,8'h00,8'h00,2'b00,1'b0,1'b0,16'h0000,16'h0008}, // R3
    {8'h80,8'h80,8'h80,8'h40,2'b11,1'b1,1'b1,16'h0000,16'h1000}, // R6
    {8'h80,8'h80,8'h80,8'h40,2'b11,1'b1,1'b0,16'h1002,16'h0002}, // R6
    {8'h0C,8'h80,8'h80,8'h40,2'b10,1'b1,1'b0,16'h0000,16'h1000}, // R6
    {8'h80,8'h80,8'h80,8'hBF,2'b11,1'b1,1'b0,16'h1000,16'h1000}, // R6
    {8'h0E,8'h07,8'h04,8'h00,2'b00,1'b0,1'b0,16'h0010,16'h4090}  // R5
  };

  task automatic check(input logic [15:0] exp, input string req);
    n_chk++;
    if (irq_req !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_req=%h expected %h", req, irq_req, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset leaves all steering off
    pci_irq_n = 2'b00; mb_irq_n = 1'b0; mouse_irq = 1'b1; isa_irq = 16'hA5A5;
    #1 check(16'hA5A5, "R1");

    for (int i = 0; i < 12; i++) begin
      wr_reg(2'd0, VEC[i][67:60]);
      wr_reg(2'd1, VEC[i][59:52]);
      wr_reg(2'd2, VEC[i][51:44]);
      wr_reg(2'd3, VEC[i][43:36]);
      pci_irq_n = VEC[i][35:34]; mb_irq_n = VEC[i][33];
      mouse_irq = VEC[i][32]; isa_irq = VEC[i][31:16];
      #1 check(VEC[i][15:0], "R3/R4/R5/R6 vector");
    end

    // R3 / R4: sweep every target value on source A
    wr_reg(2'd1, 8'h80); wr_reg(2'd2, 8'h80); wr_reg(2'd3, 8'h00);
    pci_irq_n = 2'b10; mb_irq_n = 1'b1; isa_irq = '0;
    for (int t = 0; t < 16; t++) begin
      logic [15:0] e;
      wr_reg(2'd0, 8'(t));
      e = (t == 0 || t == 1 || t == 2 || t == 8 || t == 13) ? 16'h0 : (16'h1 << t);
      #1 check(e, (e == 0) ? "R4" : "R3");
    end

    // R8: outputs follow inputs with no clock edge
    wr_reg(2'd0, 8'h06);
    @(negedge clk);
    pci_irq_n = 2'b11; #1 check(16'h0000, "R8");
    pci_irq_n = 2'b10; #1 check(16'h0040, "R8");
    isa_irq = 16'h0100; #1 check(16'h0140, "R8");
    isa_irq = '0;

    // R7: strobe low writes nothing
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h80;
    @(negedge clk);
    #1 check(16'h0040, "R7");
    // R7: value acts from the write edge, not before
    cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h04;
    #1 check(16'h0040, "R7");
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    check(16'h0010, "R7");

    // R1 again: reset restores the disabled state
    rst_n = 1'b0;
    #1 check(16'h0000, "R1");
    @(negedge clk); rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule